// File: doc/BRIEF.md
# Power-Domain Request Sequencer

This block drives one power-domain switch command at a time toward an external power-management engine and waits for that engine to confirm the change. A start strobe carries a 4-bit domain number and an on/off flag. The sequencer turns them into a single request line out of twenty. It then checks the engine's acknowledge vector and two independent power-status vectors, once per poll period. The operation ends with a one-cycle done pulse and an error flag. The flag is low when all three confirmations agreed, and high when the poll budget ran out or the domain number was not valid.

The check is deliberately strict. The acknowledge bit that matches the request must be set. The domain's own bit in both status vectors must also read back the requested state. A control-enable output stays high for as long as a request is outstanding. Both that output and the request vector drop to zero when the operation ends, whatever the outcome.

The state machine has four states. IDLE waits for start. POLL spends one cycle evaluating the confirmation. PAUSE counts out the poll interval. FINISH raises done for one cycle. The transitions are:

- accept: IDLE to POLL, on start with a valid domain.
- reject: IDLE to FINISH, on start with an invalid domain.
- confirm: POLL to FINISH, when the check succeeds.
- expire: POLL to FINISH, when the check fails and the poll budget is spent.
- retry: POLL to PAUSE, when the check fails and polls remain.
- resume: PAUSE to POLL, when the interval has elapsed.
- release: FINISH to IDLE.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset, req_vec_o is zero and ctrl_en_o, busy_o, done_o and error_o are all low.
- R2: Domain numbers 0 to 9 are valid. For an accepted start, req_vec_o has exactly one bit set: index d for a power-on (pwr_on_i=1) and index d+10 for a power-off. The bit appears in the cycle after the start edge.
- R3: Each domain checks one status bit position. Domains 0 to 9 use positions 7, 21, 5, 3, 20, 24, 23, 22, 4 and 25. A check succeeds only when three things hold: ack_vec_i has the request bit set, sta_pri_i at the domain's position equals the requested state, and sta_sec_i at that position equals it too. A success ends the operation with error_o low.
- R4: The first check happens in the cycle after the start edge. Each further check follows the previous one by POLL_GAP+1 cycles. done_o rises in the cycle after a successful check.
- R5: If MAX_POLLS+1 consecutive checks all fail, done_o rises in the cycle after the last one, with error_o high.
- R6: ctrl_en_o and busy_o are high in every cycle in which req_vec_o is non-zero. When done_o is high, req_vec_o is zero and ctrl_en_o is low. Both stay that way until the next accepted start.
- R7: A start with domain number 10 to 15 issues no request and never raises ctrl_en_o. It raises done_o with error_o high in the cycle after the start edge.
- R8: done_o is high for exactly one cycle. error_o keeps its final value until the next start.
- R9: A start strobe while busy_o is high is ignored. The request vector and the result are those of the operation already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, sampled in IDLE |
| dom_sel_i | input | 4 | Domain number |
| pwr_on_i | input | 1 | 1 = power on, 0 = power off |
| ack_vec_i | input | 20 | Acknowledge vector from the power engine |
| sta_pri_i | input | 32 | Primary power-status vector |
| sta_sec_i | input | 32 | Secondary power-status vector |
| req_vec_o | output | 20 | One-hot request vector |
| ctrl_en_o | output | 1 | High while a request is outstanding |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | Result: 1 = timeout or invalid domain |

## Verification
A corrupted state or latched field shows up quickly at the ports. A wrong latched domain or direction puts the request bit at a wrong index, visible one cycle after start. A wrong status position shifts which input pattern counts as success, so done_o arrives at a different cycle or error_o flips. Interval or poll-counter faults move the done_o edge by whole poll periods. The bench therefore compares the exact done latency and result of each operation against a model of the check schedule.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
    localparam int NUM_DOM = 10;
    localparam int REQ_W   = 2 * NUM_DOM;
    localparam int DOM_W   = 4;
    localparam int STAT_W  = 32;
    localparam int POS_W   = $clog2(STAT_W);

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_POLL   = 2'd1,
        S_PAUSE  = 2'd2,
        S_FINISH = 2'd3
    } seq_state_t;

    // Status bit position of each domain.
    function automatic logic [POS_W-1:0] stat_pos(input logic [DOM_W-1:0] dom);
        logic [POS_W-1:0] p;
        unique case (dom)
            4'd0:    p = POS_W'(7);
            4'd1:    p = POS_W'(21);
            4'd2:    p = POS_W'(5);
            4'd3:    p = POS_W'(3);
            4'd4:    p = POS_W'(20);
            4'd5:    p = POS_W'(24);
            4'd6:    p = POS_W'(23);
            4'd7:    p = POS_W'(22);
            4'd8:    p = POS_W'(4);
            4'd9:    p = POS_W'(25);
            default: p = '0;
        endcase
        return p;
    endfunction
endpackage

// File: rtl/pwr_seq_decode.sv
module pwr_seq_decode
    import pwr_seq_pkg::*;
(
    input  logic [DOM_W-1:0] dom_i,
    input  logic             on_i,
    output logic             valid_o,
    output logic [REQ_W-1:0] req_o,
    output logic [POS_W-1:0] pos_o
);
    assign valid_o = (dom_i < DOM_W'(NUM_DOM));
    assign pos_o   = stat_pos(dom_i);

    for (genvar i = 0; i < NUM_DOM; i++) begin : g_on_half
        assign req_o[i] = valid_o && on_i && (dom_i == DOM_W'(i));
    end
    for (genvar j = NUM_DOM; j < REQ_W; j++) begin : g_off_half
        assign req_o[j] = valid_o && !on_i && (dom_i == DOM_W'(j - NUM_DOM));
    end
endmodule

// File: rtl/pwr_seq_check.sv
module pwr_seq_check
    import pwr_seq_pkg::*;
(
    input  logic [REQ_W-1:0]  req_i,
    input  logic              on_i,
    input  logic [POS_W-1:0]  pos_i,
    input  logic [REQ_W-1:0]  ack_i,
    input  logic [STAT_W-1:0] sta_pri_i,
    input  logic [STAT_W-1:0] sta_sec_i,
    output logic              hit_o
);
    logic ack_ok, pri_ok, sec_ok;

    always_comb begin
        ack_ok = |(ack_i & req_i);
        pri_ok = (sta_pri_i[pos_i] == on_i);
        sec_ok = (sta_sec_i[pos_i] == on_i);
        hit_o  = ack_ok && pri_ok && sec_ok;
    end
endmodule

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
    parameter int POLL_GAP  = 4,
    parameter int MAX_POLLS = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic load_i,
    input  logic run_i,
    input  logic bump_i,
    output logic gap_done_o,
    output logic last_poll_o
);
    localparam int GW = (POLL_GAP > 1) ? $clog2(POLL_GAP + 1) : 1;
    localparam int PW = $clog2(MAX_POLLS + 2);

    logic [GW-1:0] gap_cnt;
    logic [PW-1:0] poll_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_cnt <= '0;
        end else if (load_i) begin
            gap_cnt <= GW'(POLL_GAP - 1);
        end else if (run_i && gap_cnt != '0) begin
            gap_cnt <= gap_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            poll_cnt <= '0;
        end else if (clear_i) begin
            poll_cnt <= '0;
        end else if (bump_i) begin
            poll_cnt <= poll_cnt + 1'b1;
        end
    end

    assign gap_done_o  = (gap_cnt == '0);
    assign last_poll_o = (poll_cnt == PW'(MAX_POLLS));

    AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        poll_cnt <= PW'(MAX_POLLS)); // R5
    AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> gap_cnt == GW'(POLL_GAP - 1)); // R4
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int POLL_GAP  = 4,
    parameter int MAX_POLLS = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [3:0]        dom_sel_i,
    input  logic              pwr_on_i,
    input  logic [19:0]       ack_vec_i,
    input  logic [31:0]       sta_pri_i,
    input  logic [31:0]       sta_sec_i,
    output logic [19:0]       req_vec_o,
    output logic              ctrl_en_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              error_o
);
    seq_state_t state_q, state_d;

    logic [REQ_W-1:0] req_q,  dec_req;
    logic [POS_W-1:0] pos_q,  dec_pos;
    logic             on_q,   err_q, err_d;
    logic             dec_valid, hit;
    logic             gap_done, last_poll;
    logic             accept, t_clear, t_load, t_run, t_bump;

    pwr_seq_decode u_decode (
        .dom_i   (dom_sel_i),
        .on_i    (pwr_on_i),
        .valid_o (dec_valid),
        .req_o   (dec_req),
        .pos_o   (dec_pos)
    );

    pwr_seq_check u_check (
        .req_i     (req_q),
        .on_i      (on_q),
        .pos_i     (pos_q),
        .ack_i     (ack_vec_i),
        .sta_pri_i (sta_pri_i),
        .sta_sec_i (sta_sec_i),
        .hit_o     (hit)
    );

    pwr_seq_timer #(
        .POLL_GAP  (POLL_GAP),
        .MAX_POLLS (MAX_POLLS)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (t_clear),
        .load_i      (t_load),
        .run_i       (t_run),
        .bump_i      (t_bump),
        .gap_done_o  (gap_done),
        .last_poll_o (last_poll)
    );

    // Next-state and timer control
    always_comb begin
        state_d = state_q;
        err_d   = err_q;
        accept  = 1'b0;
        t_clear = 1'b0;
        t_load  = 1'b0;
        t_run   = 1'b0;
        t_bump  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) begin
                    if (dec_valid) begin
                        state_d = S_POLL;
                        err_d   = 1'b0;
                        accept  = 1'b1;
                        t_clear = 1'b1;
                    end else begin
                        state_d = S_FINISH;
                        err_d   = 1'b1;
                    end
                end
            end
            S_POLL: begin
                if (hit) begin
                    state_d = S_FINISH;
                    err_d   = 1'b0;
                end else if (last_poll) begin
                    state_d = S_FINISH;
                    err_d   = 1'b1;
                end else begin
                    state_d = S_PAUSE;
                    t_load  = 1'b1;
                end
            end
            S_PAUSE: begin
                t_run = 1'b1;
                if (gap_done) begin
                    state_d = S_POLL;
                    t_bump  = 1'b1;
                end
            end
            S_FINISH: begin
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // State and latched-command registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            req_q   <= '0;
            pos_q   <= '0;
            on_q    <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= err_d;
            if (accept) begin
                req_q <= dec_req;
                pos_q <= dec_pos;
                on_q  <= pwr_on_i;
            end
        end
    end

    // Outputs
    always_comb begin
        req_vec_o = '0;
        ctrl_en_o = 1'b0;
        busy_o    = 1'b0;
        done_o    = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_POLL, S_PAUSE: begin
                req_vec_o = req_q;
                ctrl_en_o = 1'b1;
                busy_o    = 1'b1;
            end
            S_FINISH: begin
                busy_o = 1'b1;
                done_o = 1'b1;
            end
            default: ;
        endcase
        error_o = err_q;
    end

    AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_vec_o)); // R2
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vec_o != '0) |=> (req_vec_o == '0) || $stable(req_vec_o)); // R9
    AST_REQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vec_o != '0) |-> ctrl_en_o && busy_o); // R6
    AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (req_vec_o == '0) && !ctrl_en_o); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(error_o)); // R8
endmodule

// File: tb/test_pwr_seq_ctrl.sv
module test_pwr_seq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int GAP  = 3;
    localparam int MAXP = 5;
    localparam int PER  = GAP + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [3:0]  dom_sel_i = '0;
    logic        pwr_on_i = 1'b0;
    logic [19:0] ack_vec_i = '0;
    logic [31:0] sta_pri_i = '0;
    logic [31:0] sta_sec_i = '0;
    logic [19:0] req_vec_o;
    logic        ctrl_en_o, busy_o, done_o, error_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    pwr_seq_ctrl #(.POLL_GAP(GAP), .MAX_POLLS(MAXP)) i_pwr_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dom_sel_i(dom_sel_i),
        .pwr_on_i(pwr_on_i), .ack_vec_i(ack_vec_i), .sta_pri_i(sta_pri_i),
        .sta_sec_i(sta_sec_i), .req_vec_o(req_vec_o), .ctrl_en_o(ctrl_en_o),
        .busy_o(busy_o), .done_o(done_o), .error_o(error_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int pos_of(input int d);
        int t[10] = '{7, 21, 5, 3, 20, 24, 23, 22, 4, 25};
        return t[d];
    endfunction

    function automatic logic [19:0] exp_req(input int d, input bit on);
        if (d > 9) return '0;
        return 20'(1) << (on ? d : d + 10);
    endfunction

    // Edges from start to done (inclusive), given inputs become good from edge D+1.
    function automatic int exp_lat(input int d, input int rdy, output bit err);
        if (d > 9) begin err = 1'b1; return 1; end
        for (int k = 0; k <= MAXP; k++) begin
            if (1 + k * PER >= rdy) begin err = 1'b0; return 2 + k * PER; end
        end
        err = 1'b1;
        return 2 + MAXP * PER;
    endfunction

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic drive_pattern(input int d, input bit on, input bit good, input int mode);
        logic [31:0] p1, p2;
        logic [19:0] a;
        int ps;
        ps = (d > 9) ? 0 : pos_of(d);
        p1 = $urandom; p2 = $urandom;
        p1[ps] = on; p2[ps] = on;
        a  = 20'($urandom) | exp_req(d, on);
        if (!good) begin
            case (mode)
                0: a = a & ~exp_req(d, on);
                1: p1[ps] = !on;
                2: p2[ps] = !on;
                default: begin a = '0; p1[ps] = !on; p2[ps] = !on; end
            endcase
        end
        ack_vec_i = a; sta_pri_i = p1; sta_sec_i = p2;
    endtask

    // rdy: edge count from which good inputs are driven; mid: extra start while busy.
    task automatic run_op(input int d, input bit on, input int rdy, input int mode, input bit mid);
        int n; int lat; bit eerr; bit seen;
        logic [19:0] er;
        er  = exp_req(d, on);
        lat = exp_lat(d, rdy, eerr);
        @(negedge clk);
        dom_sel_i = 4'(d); pwr_on_i = on; start_i = 1'b1;
        drive_pattern(d, on, rdy == 0, mode);
        n = 0; seen = 1'b0;
        while (!seen && n < 200) begin
            @(posedge clk); n++;
            @(negedge clk);
            start_i = 1'b0;
            if (n == 1) begin
                check("R2", "req_vec after start", req_vec_o, (d > 9) ? 0 : er);
                check("R6", "ctrl_en while requesting", ctrl_en_o, d <= 9);
                if (d > 9) check("R7", "invalid domain done", done_o, 1);
            end
            if (mid && n == 2) begin
                start_i = 1'b1; dom_sel_i = 4'((d + 3) % 10); pwr_on_i = !on;
            end
            if (mid && n == 3) check("R9", "req unchanged by start while busy", req_vec_o, er);
            if (done_o) seen = 1'b1;
            else if (n >= rdy) drive_pattern(d, on, 1'b1, mode);
        end
        check((eerr && d <= 9) ? "R5" : "R4", "done latency", n, lat);
        check(eerr ? ((d > 9) ? "R7" : "R5") : "R3", "error result", error_o, eerr);
        check("R6", "req cleared at done", req_vec_o, 0);
        check("R6", "ctrl_en low at done", ctrl_en_o, 0);
        @(negedge clk);
        check("R8", "done one cycle", done_o, 0);
        check("R8", "error held", error_o, eerr);
        check("R6", "busy low after done", busy_o, 0);
        ack_vec_i = '0; sta_pri_i = '0; sta_sec_i = '0;
    endtask

    initial begin
        process::self().srandom(32'h5eed_1234);
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check("R1", "reset req", req_vec_o, 0);
        check("R1", "reset busy/done/err/en", {busy_o, done_o, error_o, ctrl_en_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "idle after reset", {busy_o, done_o, error_o, ctrl_en_o}, 0);

        run_op(0, 1'b1, 0, 0, 1'b0);                 // R2 R3 immediate success
        run_op(9, 1'b0, 0, 1, 1'b0);                 // R2 off half
        run_op(10, 1'b1, 0, 0, 1'b0);                // R7 invalid
        run_op(15, 1'b0, 0, 0, 1'b0);                // R7 invalid
        for (int m = 0; m < 4; m++) run_op(m + 2, m[0], 999, m, 1'b0); // R5 each failing leg
        run_op(4, 1'b1, 1 + MAXP * PER, 2, 1'b0);    // R4 success on final check
        run_op(4, 1'b1, 2 + MAXP * PER, 2, 1'b0);    // R5 one edge too late
        run_op(6, 1'b0, 9, 0, 1'b1);                 // R9 start while busy
        for (int i = 0; i < 60; i++) begin
            int d, r;
            d = ($urandom % 8 == 0) ? 10 + int'($urandom % 6) : int'($urandom % 10);
            r = ($urandom % 5 == 0) ? 999 : int'($urandom % 26);
            run_op(d, 1'($urandom), r, int'($urandom % 4), (d <= 9) && (r >= 5) && ($urandom % 3 == 0));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        wait (cyc >= 100000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule